// File: doc/BRIEF.md
# Cascaded Interrupt Status and Mask Controller

This block collects interrupt requests for an I/O controller and presents them to a processor as a single level-sensitive request line. Two kinds of source feed it. Ordinary device lines are level signals that the status register copies every cycle. DMA event lines are captured on their rising edge and held until software clears them. A mask register, with one bit per line, decides which status bits may drive the combined output.

DMA events come in two classes, chosen per line by a parameter mask. Informational events only post a status bit. They never stop their channel, and they can post again as soon as software has cleared the bit. Error events also drive a per-channel halt output. The halt stays high until software clears the matching status bit, which stops the DMA engine until the fault has been handled.

Software reaches both registers over a small word-wide register bus. One select bit picks the status or the mask register. A write strobe commits the write data. Read data appears one cycle after the select is presented. The status register is cleared by writing zeros: each bit written as 0 is cleared and each bit written as 1 is left alone.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: While reset (active-low, synchronous) is held, the status and mask registers clear. After reset, `irq_out` and every `dma_halt` bit read 0.
- R2: A bus write with `bus_sel`=1 loads the mask register from `bus_wdata[NUM_LINES-1:0]`. The value reads back unchanged.
- R3: Status bit i, for a device line (i < DMA_BASE), equals `dev_irq[i]` as sampled at the previous clock edge. Writes to the status register have no effect on device bits.
- R4: A rising edge on `dma_evt[j]` sets status bit DMA_BASE+j. The bit stays set after the line falls. A line held high does not set the bit again after a clear; only a new rising edge does.
- R5: A bus write with `bus_sel`=0 clears every DMA status bit whose write-data bit is 0 and leaves every DMA status bit whose write-data bit is 1 unchanged.
- R6: If a rising DMA edge and a clearing write hit the same status bit in the same cycle, the bit ends the cycle set.
- R7: For a DMA line whose bit in `INFO_MASK` is 0 (error class), `dma_halt[j]` is 1 while status bit DMA_BASE+j is set. It stays 1 until a status write clears that bit.
- R8: For a DMA line whose bit in `INFO_MASK` is 1 (informational class), `dma_halt[j]` is always 0.
- R9: `irq_out` is 1 exactly when some status bit and the same mask bit are both 1. Masked status bits do not affect it.
- R10: `bus_rdata` holds, one cycle after the select is presented, the status register (`bus_sel`=0) or the mask register (`bus_sel`=1). Bits at or above NUM_LINES read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_irq | input | DMA_BASE | Level request lines from devices |
| dma_evt | input | NUM_LINES-DMA_BASE | DMA event lines, edge-captured |
| bus_sel | input | 1 | Register select: 0 status, 1 mask |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_out | output | 1 | Level request to the processor |
| dma_halt | output | NUM_LINES-DMA_BASE | Per-channel stop request for error events |

## Verification
The checker checks the following on every cycle:
- the reset clearing;
- device bits following their lines one edge later;
- capture of every DMA rising edge, including the case where the edge meets a clearing write;
- halts on error channels holding until a clearing write;
- the output dropping after the mask is written to all zeros;
- mask read-back through the bus.

Some behaviours show only in the bench's scenarios, because each depends on a history of stimulus. These are:
- informational channels never halting;
- a steady-high DMA line not posting again after a clear;
- write-1 bits surviving a partial clear;
- device bits ignoring status writes.

// File: rtl/irq_cascade_pkg.sv
// Package: shared bus constants and register-select type for the
// interrupt status/mask controller.
// Assumes a single 32-bit bus word holds every interrupt line.
package irq_cascade_pkg;

    localparam int BUS_W = 32;

    typedef enum logic {
        SEL_STATUS = 1'b0,
        SEL_MASK   = 1'b1
    } reg_sel_e;

endpackage

// File: rtl/irq_mask_reg.sv
// Module: mask register, one enable bit per interrupt line.
// Loads the whole word on a decoded write strobe and clears on reset.
// Assumes the strobe is already qualified by register select.
module irq_mask_reg #(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [NUM_LINES-1:0] wdata,
    output logic [NUM_LINES-1:0] mask_q
);

    // Hold the mask; reset blocks every source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (we) begin
            mask_q <= wdata;
        end
    end

endmodule

// File: rtl/irq_status_bank.sv
// Module: status register and DMA halt generation.
// Lines below DMA_BASE are device levels copied each cycle.
// Lines from DMA_BASE upward are rising-edge captured and cleared by a
// write-0. Error-class DMA lines (INFO_MASK bit 0) also drive a halt.
// Assumes clr_keep carries the write data for the DMA bits only.
module irq_status_bank #(
    parameter int          NUM_LINES = 32,
    parameter int          DMA_BASE  = 16,
    parameter logic [31:0] INFO_MASK = 32'h0017_0000,
    localparam int         NUM_DMA   = NUM_LINES - DMA_BASE
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DMA_BASE-1:0]  dev_irq,
    input  logic [NUM_DMA-1:0]   dma_evt,
    input  logic                 clr_we,
    input  logic [NUM_DMA-1:0]   clr_keep,
    output logic [NUM_LINES-1:0] status_q,
    output logic [NUM_DMA-1:0]   dma_halt
);

    // One storage slice per line; the variant follows the line class.
    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        if (i < DMA_BASE) begin : g_dev
            // Device line: status copies the level each cycle.
            always_ff @(posedge clk) begin
                if (!rst_n) status_q[i] <= 1'b0;
                else        status_q[i] <= dev_irq[i];
            end
        end else begin : g_dma
            logic evt_prev;
            logic rise;
            logic clr;

            // Remember the line level to find rising edges.
            always_ff @(posedge clk) begin
                if (!rst_n) evt_prev <= 1'b0;
                else        evt_prev <= dma_evt[i-DMA_BASE];
            end

            // Edge and clear qualifiers for this bit.
            always_comb begin
                rise = dma_evt[i-DMA_BASE] & ~evt_prev;
                clr  = clr_we & ~clr_keep[i-DMA_BASE];
            end

            // Latch edges; a new edge beats a same-cycle clear.
            always_ff @(posedge clk) begin
                if (!rst_n) status_q[i] <= 1'b0;
                else        status_q[i] <= rise | (status_q[i] & ~clr);
            end

            if (INFO_MASK[i]) begin : g_info
                // Informational event: never halts its channel.
                assign dma_halt[i-DMA_BASE] = 1'b0;
            end else begin : g_err
                // Error event: halt while the bit is pending.
                assign dma_halt[i-DMA_BASE] = status_q[i];
            end
        end
    end

endmodule

// File: rtl/irq_bus_port.sv
// Module: register bus port.
// Decodes write strobes per register and returns a registered read
// word one cycle after the select. Assumes NUM_LINES <= BUS_W; unused
// upper read bits are zero.
module irq_bus_port
    import irq_cascade_pkg::*;
#(
    parameter int NUM_LINES = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [NUM_LINES-1:0] status_q,
    input  logic [NUM_LINES-1:0] mask_q,
    output logic                 status_we,
    output logic                 mask_we,
    output logic [BUS_W-1:0]     bus_rdata
);

    reg_sel_e          sel;
    logic [BUS_W-1:0]  rd_word;

    // Decode select into per-register write strobes and read source.
    always_comb begin
        sel       = reg_sel_e'(bus_sel);
        status_we = bus_wr && (sel == SEL_STATUS);
        mask_we   = bus_wr && (sel == SEL_MASK);
        rd_word   = '0;
        if (sel == SEL_MASK) rd_word[NUM_LINES-1:0] = mask_q;
        else                 rd_word[NUM_LINES-1:0] = status_q;
    end

    // Register the read word for a one-cycle read latency.
    always_ff @(posedge clk) begin
        if (!rst_n) bus_rdata <= '0;
        else        bus_rdata <= rd_word;
    end

endmodule

// File: rtl/irq_cascade_ctrl.sv
// Module: top of the cascaded interrupt status/mask controller.
// Joins the bus port, status bank and mask register, and drives the
// level request as the OR of unmasked pending bits.
// Assumes synchronous inputs and NUM_LINES <= 32.
module irq_cascade_ctrl
    import irq_cascade_pkg::*;
#(
    parameter int          NUM_LINES = 32,
    parameter int          DMA_BASE  = 16,
    parameter logic [31:0] INFO_MASK = 32'h0017_0000,
    localparam int         NUM_DMA   = NUM_LINES - DMA_BASE
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [DMA_BASE-1:0] dev_irq,
    input  logic [NUM_DMA-1:0]  dma_evt,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                irq_out,
    output logic [NUM_DMA-1:0]  dma_halt
);

    logic [NUM_LINES-1:0] status_q;
    logic [NUM_LINES-1:0] mask_q;
    logic                 status_we;
    logic                 mask_we;

    irq_bus_port #(.NUM_LINES(NUM_LINES)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .status_q  (status_q),
        .mask_q    (mask_q),
        .status_we (status_we),
        .mask_we   (mask_we),
        .bus_rdata (bus_rdata)
    );

    irq_status_bank #(
        .NUM_LINES (NUM_LINES),
        .DMA_BASE  (DMA_BASE),
        .INFO_MASK (INFO_MASK)
    ) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .dev_irq  (dev_irq),
        .dma_evt  (dma_evt),
        .clr_we   (status_we),
        .clr_keep (bus_wdata[NUM_LINES-1:DMA_BASE]),
        .status_q (status_q),
        .dma_halt (dma_halt)
    );

    irq_mask_reg #(.NUM_LINES(NUM_LINES)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (mask_we),
        .wdata  (bus_wdata[NUM_LINES-1:0]),
        .mask_q (mask_q)
    );

    // Level request: any pending bit whose mask bit is enabled.
    always_comb begin
        irq_out = |(status_q & mask_q);
    end

endmodule

// File: rtl/irq_cascade_chk.sv
// Module: assertion checker for irq_cascade_ctrl, bound to every
// instance. Observes ports and the status/mask registers.
module irq_cascade_chk #(
    parameter int          NUM_LINES = 32,
    parameter int          DMA_BASE  = 16,
    parameter logic [31:0] INFO_MASK = 32'h0017_0000,
    localparam int         NUM_DMA   = NUM_LINES - DMA_BASE
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [DMA_BASE-1:0]  dev_irq,
    input logic [NUM_DMA-1:0]   dma_evt,
    input logic                 bus_sel,
    input logic                 bus_wr,
    input logic [31:0]          bus_wdata,
    input logic [31:0]          bus_rdata,
    input logic                 irq_out,
    input logic [NUM_DMA-1:0]   dma_halt,
    input logic [NUM_LINES-1:0] status_q,
    input logic [NUM_LINES-1:0] mask_q
);

    // R1: a reset cycle leaves every register and output cleared.
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (status_q == '0 && mask_q == '0 && !irq_out && dma_halt == '0));

    // R10: a mask-select read returns the mask one cycle later.
    p_rdata_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr) |=> (bus_rdata[NUM_LINES-1:0] == $past(mask_q)));

    // R9: writing an all-zero mask silences the request line.
    p_mask_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel && bus_wdata[NUM_LINES-1:0] == '0) |=> !irq_out);

    // R3: device bits follow their line one edge later.
    for (genvar i = 0; i < DMA_BASE; i++) begin : g_dev_chk
        p_dev_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (status_q[i] == $past(dev_irq[i])));
    end

    for (genvar j = 0; j < NUM_DMA; j++) begin : g_dma_chk
        // R4: a rising event edge always posts its bit.
        p_edge_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(dma_evt[j]) |=> status_q[DMA_BASE+j]);

        // R6: a rising edge beats a same-cycle clearing write.
        p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
            ($rose(dma_evt[j]) && bus_wr && !bus_sel && !bus_wdata[DMA_BASE+j])
            |=> status_q[DMA_BASE+j]);

        if (!INFO_MASK[DMA_BASE+j]) begin : g_err_chk
            // R7: an error halt holds until a clearing status write.
            p_halt_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
                (dma_halt[j] && !(bus_wr && !bus_sel && !bus_wdata[DMA_BASE+j]))
                |=> dma_halt[j]);
        end
    end

endmodule

bind irq_cascade_ctrl irq_cascade_chk #(
    .NUM_LINES (NUM_LINES),
    .DMA_BASE  (DMA_BASE),
    .INFO_MASK (INFO_MASK)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dev_irq   (dev_irq),
    .dma_evt   (dma_evt),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_out   (irq_out),
    .dma_halt  (dma_halt),
    .status_q  (status_q),
    .mask_q    (mask_q)
);

// File: tb/irq_cascade_ctrl_tb.sv
// Directed bench for irq_cascade_ctrl with default parameters:
// 32 lines, DMA lines 16..31, informational lines 16,17,18,20.
module irq_cascade_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] dev_irq = '0;
    logic [15:0] dma_evt = '0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_out;
    logic [15:0] dma_halt;

    int n_checks = 0;
    int n_errors = 0;

    irq_cascade_ctrl dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .dev_irq   (dev_irq),
        .dma_evt   (dma_evt),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out),
        .dma_halt  (dma_halt)
    );

    always #5 clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic sel, input logic [31:0] data);
        @(negedge clk);
        bus_sel = sel; bus_wr = 1'b1; bus_wdata = data;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic sel, output logic [31:0] data);
        @(negedge clk);
        bus_sel = sel; bus_wr = 1'b0;
        @(negedge clk);
        data = bus_rdata;
    endtask

    task automatic pulse_dma(input int ch);
        @(negedge clk); dma_evt[ch] = 1'b1;
        @(negedge clk); dma_evt[ch] = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        bus_read(1'b0, v); check("R1 status after reset", v, 32'h0);
        bus_read(1'b1, v); check("R1 mask after reset", v, 32'h0);
        check("R1 irq_out after reset", {31'b0, irq_out}, 32'h0);
        check("R1 halt after reset", {16'b0, dma_halt}, 32'h0);
    endtask

    task automatic t_mask_rw();
        logic [31:0] v;
        bus_write(1'b1, 32'hA5C3_F00F);
        bus_read(1'b1, v); check("R2 mask readback", v, 32'hA5C3_F00F);
        bus_write(1'b1, 32'h0);
        bus_read(1'b1, v); check("R10 mask zero readback", v, 32'h0);
    endtask

    task automatic t_dev_follow();
        logic [31:0] v;
        bus_write(1'b1, 32'hFFFF_FFFF);
        @(negedge clk); dev_irq[3] = 1'b1;
        @(negedge clk);
        check("R3 status follows dev line", {31'b0, irq_out}, 32'h1);
        bus_read(1'b0, v); check("R3 dev status bit", v, 32'h0000_0008);
        bus_write(1'b0, 32'h0);
        bus_read(1'b0, v); check("R3 write ignored on dev bit", v, 32'h0000_0008);
        @(negedge clk); dev_irq[3] = 1'b0;
        @(negedge clk);
        bus_read(1'b0, v); check("R3 dev bit drops with line", v, 32'h0);
        check("R9 irq low with no pending", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_err_dma();
        logic [31:0] v;
        pulse_dma(0);
        pulse_dma(3);
        bus_read(1'b0, v); check("R4 edges captured and held", v, 32'h0009_0000);
        check("R7 halt on error channel", {16'b0, dma_halt}, 32'h0000_0008);
        repeat (3) @(negedge clk);
        check("R7 halt held", {16'b0, dma_halt}, 32'h0000_0008);
        bus_write(1'b0, ~32'h0008_0000);
        bus_read(1'b0, v); check("R5 write-0 clears, write-1 keeps", v, 32'h0001_0000);
        check("R7 halt released by clear", {16'b0, dma_halt}, 32'h0);
        bus_write(1'b0, 32'h0);
        bus_read(1'b0, v); check("R5 full clear", v, 32'h0);
    endtask

    task automatic t_info_dma();
        logic [31:0] v;
        pulse_dma(0); pulse_dma(1); pulse_dma(2); pulse_dma(4);
        bus_read(1'b0, v); check("R4 info bits posted", v, 32'h0017_0000);
        check("R8 info events never halt", {16'b0, dma_halt}, 32'h0);
        bus_write(1'b0, 32'h0);
        pulse_dma(4);
        bus_read(1'b0, v); check("R4 info bit re-posts after clear", v, 32'h0010_0000);
        bus_write(1'b0, 32'h0);
    endtask

    task automatic t_steady_high();
        logic [31:0] v;
        @(negedge clk); dma_evt[5] = 1'b1;
        @(negedge clk);
        bus_write(1'b0, 32'h0);
        repeat (2) @(negedge clk);
        bus_read(1'b0, v); check("R4 steady high no re-post", v, 32'h0);
        @(negedge clk); dma_evt[5] = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b1; bus_wdata = 32'h0; dma_evt[6] = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; dma_evt[6] = 1'b0;
        bus_read(1'b0, v); check("R6 edge beats clear", v, 32'h0040_0000);
        check("R7 halt from surviving bit", {16'b0, dma_halt}, 32'h0000_0040);
    endtask

    task automatic t_irq_mask();
        logic [31:0] v;
        bus_write(1'b1, 32'h0);
        check("R9 masked pending blocked", {31'b0, irq_out}, 32'h0);
        bus_write(1'b1, 32'hFFBF_FFFF);
        check("R9 other bits enabled only", {31'b0, irq_out}, 32'h0);
        bus_write(1'b1, 32'h0040_0000);
        check("R9 enabled pending raises", {31'b0, irq_out}, 32'h1);
        bus_write(1'b0, 32'h0);
        check("R9 cleared pending drops", {31'b0, irq_out}, 32'h0);
        bus_read(1'b1, v); check("R10 mask read", v, 32'h0040_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_mask_rw();
        t_dev_follow();
        t_err_dma();
        t_info_dma();
        t_steady_high();
        t_set_wins();
        t_irq_mask();
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        #200000;
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule